// File: doc/BRIEF.md
# Packet-Aware Receive FIFO with Two Watermarks

This block buffers received bytes between a network MAC, which pushes them, and a host, which pops them. Each stored entry is one data byte plus a tag bit marking the final byte of a frame. The block tracks how full it is and how many whole frames it holds. It reports this to the host through two registered watermark outputs. Each watermark has its own threshold input.

The low watermark compares the fill level against threshold one. The high watermark compares the fill level against threshold two. The high watermark also rises as soon as at least one complete frame is resident, whatever the fill level. The host can therefore use it to start either a whole-frame read or a fixed-size read burst. During a read, an end-of-frame output marks the byte that closes a frame. A fixed-size burst can use it to stop early.

Fill tracking is a three-state machine: `LV_EMPTY`, `LV_PART` and `LV_FULL`.
- `LV_EMPTY` goes to `LV_PART` on a push.
- `LV_PART` goes to `LV_FULL` on a push without a pop when one free entry is left.
- `LV_PART` goes to `LV_EMPTY` on a pop without a push when one entry is left.
- `LV_FULL` goes to `LV_PART` on any pop.

Writes are accepted only outside `LV_FULL`. Reads are performed only outside `LV_EMPTY`. The depth is 2^AW entries (2048 by default). The thresholds are TW bits wide (12 by default), so they reach the largest frame size and beyond.

Top module: `rxq_fifo`

## Requirements
- R1: While reset is low, wm_lo, wm_hi, overflow, underflow, rd_eof and rd_data are all 0, and the FIFO becomes empty.
- R2: Bytes are popped in the order they were pushed. rd_data shows a popped byte in the cycle after the clock edge where rd_en was sampled high on a non-empty FIFO. rd_data holds its value when no pop occurs.
- R3: One cycle after any clock edge, wm_lo equals (fill level after that edge >= thr_lo).
- R4: One cycle after any clock edge, wm_hi is 1 if the fill level after that edge is >= thr_hi.
- R5: wm_hi is also 1, with the same one-cycle timing, whenever the FIFO holds at least one byte whose end-of-frame tag (wr_eof at push time) is 1. Otherwise it follows R4 alone.
- R6: rd_eof is 1 in the cycle after a pop, exactly when the popped byte carries the end-of-frame tag. It is 0 after any cycle without a pop.
- R7: A write while the FIFO holds 2^AW bytes is dropped, leaving the stored data unchanged, and sets the sticky overflow flag.
- R8: A read while the FIFO is empty pops nothing, leaves rd_data unchanged, drives rd_eof to 0 and sets the sticky underflow flag.
- R9: clr_flags clears both sticky flags at the next edge. A new overflow or underflow event in the same cycle wins, and that flag stays set.
- R10: A simultaneous write and read on a FIFO that is neither full nor empty moves one byte in and one out and leaves the fill level unchanged. On a full FIFO, the read happens and the write is dropped. On an empty FIFO, the write happens and the read underflows.
- R11: A threshold equal to the depth asserts its fill condition only when the FIFO is full. A threshold above the depth never asserts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push request from the MAC side |
| wr_data | input | 8 | Byte to push |
| wr_eof | input | 1 | Pushed byte closes a frame |
| rd_en | input | 1 | Pop request from the host side |
| rd_data | output | 8 | Last popped byte |
| rd_eof | output | 1 | Last popped byte closes a frame |
| thr_lo | input | TW | Threshold for wm_lo |
| thr_hi | input | TW | Threshold for wm_hi |
| wm_lo | output | 1 | Low watermark |
| wm_hi | output | 1 | High watermark (level or whole frame present) |
| clr_flags | input | 1 | Clears the sticky error flags |
| overflow | output | 1 | Sticky: write attempted while full |
| underflow | output | 1 | Sticky: read attempted while empty |

## Verification
The hardest situations to reach are the edges of the fill state machine under simultaneous traffic. The bench must reach a write and a read in one cycle while `LV_FULL`, and again while `LV_EMPTY`. There, one side is dropped and the other still acts. It must also reach the high watermark held up only by a resident frame while the level is far below threshold two.

The bench runs a small 16-entry configuration. It fills the FIFO to the brim and past it, then tries simultaneous traffic at both ends. Separately, it sweeps both thresholds across every value from 0 to 17 while filling and draining. It also streams frames of lengths 1 to 5 with threshold two out of reach, so the frame condition alone drives wm_hi.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        LV_EMPTY = 2'd0,
        LV_PART  = 2'd1,
        LV_FULL  = 2'd2
    } lvl_state_e;

    typedef struct packed {
        logic       eof;
        logic [7:0] data;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       pop,
    input  rxq_entry_t wr_entry,
    output logic       head_eof,
    output logic [7:0] rd_data,
    output logic       rd_eof
);
    localparam int DEPTH = 1 << AW;

    rxq_entry_t mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    rxq_entry_t head;

    assign head     = mem[rptr];
    assign head_eof = head.eof;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            rd_data <= '0;
            rd_eof  <= 1'b0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop) begin
                rptr    <= rptr + 1'b1;
                rd_data <= head.data;
                rd_eof  <= head.eof;
            end else begin
                rd_eof  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rxq_level.sv
module rxq_level
    import rxq_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_req,
    input  logic        rd_req,
    input  logic        wr_eof,
    input  logic        head_eof,
    input  logic        clr,
    output logic        push,
    output logic        pop,
    output logic [AW:0] level,
    output logic [AW:0] level_nxt,
    output logic [AW:0] pkt,
    output logic [AW:0] pkt_nxt,
    output logic        ovf,
    output logic        unf
);
    localparam int          DEPTH  = 1 << AW;
    localparam logic [AW:0] LV_TOP = (AW+1)'(DEPTH - 1);
    localparam logic [AW:0] ONE    = (AW+1)'(1);

    lvl_state_e st, st_nxt;
    logic       ovf_evt, unf_evt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= LV_EMPTY;
            level <= '0;
            pkt   <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else begin
            st    <= st_nxt;
            level <= level_nxt;
            pkt   <= pkt_nxt;
            ovf   <= (ovf && !clr) || ovf_evt;
            unf   <= (unf && !clr) || unf_evt;
        end
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            LV_EMPTY: if (push) st_nxt = LV_PART;
            LV_PART: begin
                if (push && !pop && level == LV_TOP)    st_nxt = LV_FULL;
                else if (pop && !push && level == ONE)  st_nxt = LV_EMPTY;
            end
            LV_FULL:  if (pop) st_nxt = LV_PART;
            default:  st_nxt = LV_EMPTY;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        push      = wr_req && (st != LV_FULL);
        pop       = rd_req && (st != LV_EMPTY);
        ovf_evt   = wr_req && (st == LV_FULL);
        unf_evt   = rd_req && (st == LV_EMPTY);
        level_nxt = level + (AW+1)'(push) - (AW+1)'(pop);
        pkt_nxt   = pkt + (AW+1)'(push && wr_eof) - (AW+1)'(pop && head_eof);
    end
endmodule

// File: rtl/rxq_mark.sv
module rxq_mark #(
    parameter int AW = 11,
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW:0]   level_nxt,
    input  logic          pkt_any_nxt,
    input  logic [TW-1:0] thr_lo,
    input  logic [TW-1:0] thr_hi,
    output logic          wm_lo,
    output logic          wm_hi
);
    localparam int CW = (TW > AW + 1) ? TW : AW + 1;

    logic [CW-1:0] lvl_w, lo_w, hi_w;

    assign lvl_w = CW'(level_nxt);
    assign lo_w  = CW'(thr_lo);
    assign hi_w  = CW'(thr_hi);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wm_lo <= 1'b0;
            wm_hi <= 1'b0;
        end else begin
            wm_lo <= (lvl_w >= lo_w);
            wm_hi <= (lvl_w >= hi_w) || pkt_any_nxt;
        end
    end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int AW = 11,
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          wr_eof,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_eof,
    input  logic [TW-1:0] thr_lo,
    input  logic [TW-1:0] thr_hi,
    output logic          wm_lo,
    output logic          wm_hi,
    input  logic          clr_flags,
    output logic          overflow,
    output logic          underflow
);
    logic        push, pop, head_eof;
    logic [AW:0] level, level_nxt, pkt_cnt, pkt_nxt;
    rxq_entry_t  wr_entry;

    assign wr_entry = '{eof: wr_eof, data: wr_data};

    rxq_level #(.AW(AW)) u_level (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_en), .rd_req(rd_en),
        .wr_eof(wr_eof), .head_eof(head_eof), .clr(clr_flags),
        .push(push), .pop(pop), .level(level), .level_nxt(level_nxt),
        .pkt(pkt_cnt), .pkt_nxt(pkt_nxt), .ovf(overflow), .unf(underflow)
    );

    rxq_store #(.AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wr_entry(wr_entry), .head_eof(head_eof),
        .rd_data(rd_data), .rd_eof(rd_eof)
    );

    rxq_mark #(.AW(AW), .TW(TW)) u_mark (
        .clk(clk), .rst_n(rst_n), .level_nxt(level_nxt),
        .pkt_any_nxt(pkt_nxt != '0), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .wm_lo(wm_lo), .wm_hi(wm_hi)
    );
endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
    parameter int AW = 11,
    parameter int TW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          clr_flags,
    input logic [TW-1:0] thr_lo,
    input logic [TW-1:0] thr_hi,
    input logic          wm_lo,
    input logic          wm_hi,
    input logic          overflow,
    input logic          underflow,
    input logic          rd_eof,
    input logic [AW:0]   level,
    input logic [AW:0]   pkt_cnt
);
    localparam int          CW    = (TW > AW + 1) ? TW : AW + 1;
    localparam logic [AW:0] DEPTH = (AW+1)'(1 << AW);

    a_r3_wm_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (wm_lo == (CW'(level) >= CW'($past(thr_lo)))));

    a_r5_wm_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (wm_hi == ((CW'(level) >= CW'($past(thr_hi))) || (pkt_cnt != '0))));

    a_r6_eof_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_eof |-> $past(rd_en));

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr_flags) |=> overflow);

    a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH);

    a_r8_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !clr_flags) |=> underflow);

    a_r9_clear_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flags && !wr_en) |=> !overflow);

    a_r5_pkt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_cnt <= level);
endmodule

bind rxq_fifo rxq_fifo_chk #(.AW(AW), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .clr_flags(clr_flags), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .wm_lo(wm_lo), .wm_hi(wm_hi), .overflow(overflow),
    .underflow(underflow), .rd_eof(rd_eof), .level(level), .pkt_cnt(pkt_cnt)
);

// File: tb/sim_rxq_fifo.sv
module sim_rxq_fifo;
    localparam int AW    = 4;
    localparam int TW    = 5;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n, wr_en, wr_eof, rd_en, clr_flags;
    logic [7:0]    wr_data;
    logic [TW-1:0] thr_lo, thr_hi;
    logic [7:0]    rd_data;
    logic          rd_eof, wm_lo, wm_hi, overflow, underflow;

    always #10 clk = ~clk;

    rxq_fifo #(.AW(AW), .TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_eof(wr_eof), .rd_en(rd_en), .rd_data(rd_data), .rd_eof(rd_eof),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .wm_lo(wm_lo), .wm_hi(wm_hi),
        .clr_flags(clr_flags), .overflow(overflow), .underflow(underflow)
    );

    int         n_chk = 0, n_bad = 0;
    string      phase = "R1 reset";
    logic [8:0] q[$];
    int         pkt = 0;
    logic       e_ovf = 0, e_unf = 0, e_eof = 0;
    logic [7:0] e_data = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
        end
    endtask

    task automatic step(bit w, logic [7:0] d, bit e, bit r, bit c);
        bit full = (q.size() == DEPTH);
        bit emp  = (q.size() == 0);
        bit x_lo, x_hi;
        wr_en = w; wr_data = d; wr_eof = e; rd_en = r; clr_flags = c;
        if (c) begin e_ovf = 0; e_unf = 0; end
        if (r && !emp) begin
            e_data = q[0][7:0];
            e_eof  = q[0][8];
            if (q[0][8]) pkt--;
            void'(q.pop_front());
        end else begin
            e_eof = 0;
            if (r) e_unf = 1;
        end
        if (w && !full) begin
            q.push_back({e, d});
            if (e) pkt++;
        end else if (w) begin
            e_ovf = 1;
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0; clr_flags = 0; wr_eof = 0;
        x_lo = (q.size() >= int'(thr_lo));
        x_hi = (q.size() >= int'(thr_hi)) || (pkt != 0);
        chk(wm_lo == x_lo, "R3", wm_lo, x_lo);
        chk(wm_hi == x_hi, "R4,R5", wm_hi, x_hi);
        chk(rd_data == e_data, "R2", rd_data, e_data);
        chk(rd_eof == e_eof, "R6", rd_eof, e_eof);
        chk(overflow == e_ovf, "R7", overflow, e_ovf);
        chk(underflow == e_unf, "R8", underflow, e_unf);
    endtask

    task automatic drain();
        while (q.size() != 0) step(0, 0, 0, 1, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; wr_en = 0; wr_data = 0; wr_eof = 0; rd_en = 0;
        clr_flags = 0; thr_lo = 0; thr_hi = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk({wm_lo, wm_hi, overflow, underflow, rd_eof} == 5'b0, "R1",
            {wm_lo, wm_hi, overflow, underflow, rd_eof}, 0);
        chk(rd_data == 8'd0, "R1", rd_data, 0);
        rst_n = 1;

        // R3 R4 R11: threshold sweep, no frame tags, fill to the brim and drain
        phase = "R3 R4 R11 threshold sweep";
        for (int t = 0; t <= DEPTH + 1; t++) begin
            thr_lo = TW'(t);
            thr_hi = TW'(DEPTH + 1 - t);
            for (int i = 0; i < DEPTH; i++) step(1, 8'(t * 16 + i), 0, 0, 0);
            drain();
        end

        // R2 R5 R6: frames of several lengths, threshold two out of reach
        phase = "R2 R5 R6 frames";
        thr_lo = TW'(DEPTH + 1);
        thr_hi = TW'(31);
        for (int len = 1; len <= 5; len++) begin
            for (int p = 0; p < 3; p++)
                for (int b = 0; b < len; b++)
                    step(1, 8'(len * 40 + p * 8 + b), b == len - 1, 0, 0);
            drain();
            step(1, 8'(len), 0, 0, 0);
            step(1, 8'(len + 1), 1, 1, 0);
            drain();
        end

        // R7: overflow drops writes and keeps contents
        phase = "R7 overflow";
        for (int i = 0; i < DEPTH; i++) step(1, 8'(200 + i), i[0], 0, 0);
        for (int i = 0; i < 3; i++) step(1, 8'hEE, 1, 0, 0);
        drain();

        // R8: underflow keeps rd_data
        phase = "R8 underflow";
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0);

        // R9: clear, then clear with a coincident event
        phase = "R9 clear";
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 1);

        // R10: simultaneous traffic in each fill state
        phase = "R10 simultaneous";
        thr_lo = TW'(8);
        thr_hi = TW'(9);
        for (int i = 0; i < 8; i++) step(1, 8'(i), 0, 0, 0);
        for (int i = 0; i < 20; i++) step(1, 8'(100 + i), i % 5 == 4, 1, 0);
        step(0, 0, 0, 0, 1);
        while (q.size() < DEPTH) step(1, 8'(q.size()), 0, 0, 0);
        for (int i = 0; i < 3; i++) step(1, 8'(60 + i), 1, 1, 0);
        drain();
        step(0, 0, 0, 0, 1);
        step(1, 8'h5A, 1, 1, 0);
        drain();
        step(0, 0, 0, 0, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule